// File: doc/BRIEF.md
# CPU bus cycle sequencer

This block stands between a processor core and an external system bus. It runs one bus cycle at a time. For each cycle it drives a 4-bit status code, the address, the write data and the read and write strobes. An active-low ready input lets the far side stretch the cycle. When the cycle ends, the block returns the read data and a one-clock done pulse to the core.

The block also lets an external master take the bus. A hold request is acted on only after it has been held high for three clocks, and only between cycles. While the external master owns the bus, the block raises hold acknowledge and stalls the core. An active-low lock output marks locked cycles and interrupt acknowledge cycles.

Once reset is released, the block fetches code from the restart address on its own, before any core request is taken.

The sequencer is built around four states:
- `S_CYCLE`: a bus cycle is active.
- `S_IDLE`: no cycle is active.
- `S_HALT`: a halt request is being shown.
- `S_HOLD`: the bus is handed to the external master.

It has these transitions:
- Reset enters `S_CYCLE` with the boot fetch loaded.
- `S_IDLE` goes to `S_HOLD` when the hold request is qualified. Hold has priority over a pending request.
- Otherwise `S_IDLE` goes to `S_HALT` on a halt request, or to `S_CYCLE` when it takes a request.
- `S_CYCLE` goes to `S_IDLE` on the edge at which `bus_ready_n` is low.
- `S_HALT` goes to `S_HOLD` on a qualified hold, or to `S_IDLE` once the halt request is withdrawn.
- `S_HOLD` goes to `S_IDLE` on the edge at which `hold_req` is low.

Top module: `bus_cycle_seq`

## Requirements
- R1: The `req_kind` input selects the cycle and `bus_status` shows its code, as listed below. `bus_status` never carries any other value.

  | `req_kind` | Cycle | `bus_status` |
  |---|---|---|
  | 0 | interrupt acknowledge | 0000 |
  | 1 | I/O read | 0101 |
  | 2 | I/O write | 0110 |
  | 3 | halt | 1000 |
  | 4 | memory read | 1001 |
  | 5 | memory write | 1010 |
  | 6 | code fetch | 1101 |
  | 7 | code fetch | 1101 |

- R2: A cycle with `bus_ready_n` low at its first edge lasts one clock. Each edge at which `bus_ready_n` is sampled high adds one clock. Status, address and strobes stay stable while the cycle is stretched.
- R3: A qualified hold request never ends or interrupts a cycle in progress. Hold is entered only from idle or halt. In idle, hold has priority over a pending core request.
- R4: While hold is in effect:
  - `hold_ack` is 1, `bus_status` is 1111, `bus_lock_n` is 1, and `bus_rd_n` and `bus_wr_n` are both 1.
  - `req_take` stays 0, so core requests are stalled.
  - The block leaves hold on the edge at which `hold_req` is low. The stalled request is then taken.
- R5: `hold_req` must be high at three consecutive rising edges before it counts. After the third edge, hold is entered at the next edge if the block is idle. Shorter pulses have no effect on `hold_ack`.
- R6: `bus_lock_n` is 0 for the whole of a cycle requested with `req_lock` = 1, and for the whole of every interrupt acknowledge cycle. In all other cases it is 1.
- R7: While reset is asserted, and in the first cycle after release, the block shows a code fetch (1101) from address 20'hFFFF0. It takes no core request before that fetch completes.
- R8: `bus_status` is 1111 on every clock with no active cycle. A halt request (kind 3) is never taken. It shows 1000 from the next edge until the clock after the core withdraws it.
- R9: `rsp_done` is 1 for exactly one clock, the clock after the edge at which `bus_ready_n` was sampled low. For read-type cycles, `rsp_rdata` then holds `bus_rdata` from that edge.
- R10: Strobes and the request handshake:
  - `bus_rd_n` is 0 during interrupt acknowledge, I/O read, memory read and code fetch cycles.
  - `bus_wr_n` is 0 during write cycles, with `bus_wdata` equal to the request's write data.
  - `req_take` is 1 in the clock in which the block accepts the presented request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 3 | Cycle kind code (R1) |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Request write data |
| req_lock | input | 1 | Request belongs to a locked instruction |
| req_take | output | 1 | Request accepted this clock |
| rsp_done | output | 1 | Cycle finished pulse |
| rsp_rdata | output | 16 | Latched read data |
| bus_status | output | 4 | Bus status code |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ready_n | input | 1 | Active-low ready from the bus |
| bus_rdata | input | 16 | Read data from the bus |
| bus_lock_n | output | 1 | Active-low bus lock |
| hold_req | input | 1 | Hold request from an external master |
| hold_ack | output | 1 | Hold acknowledge |

## Verification
Three events can fall on the same edge:
- the hold qualifier reaching its third high sample,
- a stretched cycle still waiting on `bus_ready_n`,
- the done pulse of that cycle.

The bench raises `hold_req` in the same clock as it presents a memory read, and holds ready off for several clocks. Hold therefore qualifies in the middle of the cycle. While the cycle is stretched, the status must stay at the read code with `hold_ack` low. The clock that carries `rsp_done` must still show `hold_ack` low, and acknowledge may appear only in the clock after it.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        K_INTA  = 3'd0,
        K_IORD  = 3'd1,
        K_IOWR  = 3'd2,
        K_HALT  = 3'd3,
        K_MEMRD = 3'd4,
        K_MEMWR = 3'd5,
        K_FETCH = 3'd6,
        K_SPARE = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CYCLE = 2'd1,
        S_HALT  = 2'd2,
        S_HOLD  = 2'd3
    } seq_state_e;

    localparam logic [3:0] ST_INTA  = 4'b0000;
    localparam logic [3:0] ST_IORD  = 4'b0101;
    localparam logic [3:0] ST_IOWR  = 4'b0110;
    localparam logic [3:0] ST_HALT  = 4'b1000;
    localparam logic [3:0] ST_MEMRD = 4'b1001;
    localparam logic [3:0] ST_MEMWR = 4'b1010;
    localparam logic [3:0] ST_FETCH = 4'b1101;
    localparam logic [3:0] ST_IDLE  = 4'b1111;

    function automatic logic kind_is_write(input req_kind_e k);
        return (k == K_IOWR) || (k == K_MEMWR);
    endfunction

    function automatic logic kind_is_read(input req_kind_e k);
        return (k != K_HALT) && !kind_is_write(k);
    endfunction

endpackage

// File: rtl/bcs_hold_qual.sv
module bcs_hold_qual #(
    parameter int HOLD_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    output logic hold_valid
);
    localparam int CW = $clog2(HOLD_MIN + 1);
    localparam logic [CW-1:0] CMAX = CW'(HOLD_MIN);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!hold_req) begin
            run_cnt <= '0;
        end else if (run_cnt != CMAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign hold_valid = (run_cnt == CMAX);

    // R5: qualification needs the request high on the two latest edges at least
    p_qual_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_valid) |-> ($past(hold_req) && $past(hold_req, 2)));

endmodule

// File: rtl/bcs_status_enc.sv
module bcs_status_enc
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state,
    input  req_kind_e  cur_kind,
    output logic [3:0] status,
    output logic       rd_n,
    output logic       wr_n,
    output logic       cyc
);
    always_comb begin
        status = ST_IDLE;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        cyc    = 1'b0;
        unique case (state)
            S_IDLE:  status = ST_IDLE;
            S_HOLD:  status = ST_IDLE;
            S_HALT:  status = ST_HALT;
            S_CYCLE: begin
                cyc  = 1'b1;
                rd_n = !kind_is_read(cur_kind);
                wr_n = !kind_is_write(cur_kind);
                unique case (cur_kind)
                    K_INTA:  status = ST_INTA;
                    K_IORD:  status = ST_IORD;
                    K_IOWR:  status = ST_IOWR;
                    K_HALT:  status = ST_HALT;
                    K_MEMRD: status = ST_MEMRD;
                    K_MEMWR: status = ST_MEMWR;
                    K_FETCH: status = ST_FETCH;
                    K_SPARE: status = ST_FETCH;
                    default: status = ST_FETCH;
                endcase
            end
            default: status = ST_IDLE;
        endcase
    end

    // R1: only the eight defined codes ever reach the bus
    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_INTA)  || (status == ST_IORD)  || (status == ST_IOWR) ||
        (status == ST_HALT)  || (status == ST_MEMRD) || (status == ST_MEMWR) ||
        (status == ST_FETCH) || (status == ST_IDLE));

    // R10: the two strobes are never active together
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter int              DATA_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  req_kind_e         req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_lock,
    input  logic              bus_ready_n,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              hold_req,
    input  logic              hold_valid,
    output seq_state_e        state,
    output req_kind_e         cur_kind,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_lock,
    output logic              req_take,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);
    seq_state_e state_nx;
    logic       halt_req;
    logic       cyc_end;

    assign halt_req = req_valid && (req_kind == K_HALT);
    assign cyc_end  = (state == S_CYCLE) && !bus_ready_n;
    assign req_take = (state == S_IDLE) && !hold_valid && req_valid && !halt_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_CYCLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (hold_valid)     state_nx = S_HOLD;
                else if (halt_req)  state_nx = S_HALT;
                else if (req_valid) state_nx = S_CYCLE;
            end
            S_CYCLE: if (!bus_ready_n) state_nx = S_IDLE;
            S_HALT: begin
                if (hold_valid)     state_nx = S_HOLD;
                else if (!halt_req) state_nx = S_IDLE;
            end
            S_HOLD: if (!hold_req) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // cycle context and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind  <= K_FETCH;
            cur_addr  <= RESET_ADDR;
            cur_wdata <= '0;
            cur_lock  <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= cyc_end;
            if (cyc_end && kind_is_read(cur_kind)) rsp_rdata <= bus_rdata;
            if (req_take) begin
                cur_kind  <= req_kind;
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
                cur_lock  <= req_lock;
            end
        end
    end

    // R3: a running cycle is never followed directly by hold
    p_no_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CYCLE) |=> (state != S_HOLD));

    // R2: a not-ready sample keeps the cycle going
    p_stretch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_CYCLE) && bus_ready_n) |=> (state == S_CYCLE));

    // R9: the done pulse never lasts two clocks
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R4: while hold lasts nothing is accepted
    p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> !req_take);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int                ADDR_W     = 20,
    parameter int                DATA_W     = 16,
    parameter int                HOLD_MIN   = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_lock,
    output logic              req_take,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [3:0]        bus_status,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    input  logic              bus_ready_n,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_lock_n,
    input  logic              hold_req,
    output logic              hold_ack
);
    seq_state_e state;
    req_kind_e  cur_kind;
    logic       cur_lock;
    logic       hold_valid;
    logic       cyc;

    bcs_hold_qual #(.HOLD_MIN(HOLD_MIN)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req   (hold_req),
        .hold_valid (hold_valid)
    );

    bcs_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind_e'(req_kind)),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_lock    (req_lock),
        .bus_ready_n (bus_ready_n),
        .bus_rdata   (bus_rdata),
        .hold_req    (hold_req),
        .hold_valid  (hold_valid),
        .state       (state),
        .cur_kind    (cur_kind),
        .cur_addr    (bus_addr),
        .cur_wdata   (bus_wdata),
        .cur_lock    (cur_lock),
        .req_take    (req_take),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata)
    );

    bcs_status_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .cur_kind (cur_kind),
        .status   (bus_status),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .cyc      (cyc)
    );

    assign bus_lock_n = !(cyc && (cur_lock || (cur_kind == K_INTA)));
    assign hold_ack   = (state == S_HOLD);

    // R6: interrupt acknowledge on the bus always carries lock
    p_lock_inta_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_status == ST_INTA) |-> !bus_lock_n);

    // R4: during hold the status is idle and lock released
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> ((bus_status == ST_IDLE) && bus_lock_n && bus_rd_n && bus_wr_n));

    // R2: a stretched cycle keeps its status and address
    p_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && bus_ready_n) |=> ($stable(bus_status) && $stable(bus_addr)));

endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;

    typedef struct packed {
        logic [2:0]  kind;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic        lock;
        logic [3:0]  waits;
        logic [15:0] rdata;
        logic [3:0]  st;
        logic        lock_n;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{3'd4, 20'h12345, 16'h0000, 1'b0, 4'd0, 16'hBEEF, 4'b1001, 1'b1},
        '{3'd5, 20'h0ABCD, 16'h1234, 1'b1, 4'd2, 16'h0000, 4'b1010, 1'b0},
        '{3'd1, 20'h00080, 16'h0000, 1'b0, 4'd1, 16'h5A5A, 4'b0101, 1'b1},
        '{3'd2, 20'h000F0, 16'hCAFE, 1'b0, 4'd0, 16'h0000, 4'b0110, 1'b1},
        '{3'd0, 20'h00000, 16'h0000, 1'b0, 4'd3, 16'h0042, 4'b0000, 1'b0},
        '{3'd6, 20'h10000, 16'h0000, 1'b0, 4'd0, 16'h9090, 4'b1101, 1'b1},
        '{3'd7, 20'h00100, 16'h0000, 1'b0, 4'd1, 16'h1111, 4'b1101, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_lock = 1'b0;
    logic        req_take;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [3:0]  bus_status;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic        bus_ready_n = 1'b1;
    logic [15:0] bus_rdata = '0;
    logic        bus_lock_n;
    logic        hold_req = 1'b0;
    logic        hold_ack;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    bus_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lock(req_lock),
        .req_take(req_take), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_status(bus_status), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ready_n(bus_ready_n),
        .bus_rdata(bus_rdata), .bus_lock_n(bus_lock_n), .hold_req(hold_req),
        .hold_ack(hold_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic bit st_is_read(input logic [3:0] s);
        return (s == 4'b0000) || (s == 4'b0101) || (s == 4'b1001) || (s == 4'b1101);
    endfunction

    // one full cycle, request presented from idle
    task automatic run_vec(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_kind = v.kind; req_addr = v.addr;
        req_wdata = v.wdata; req_lock = v.lock;
        #1;
        chk(req_take == 1'b1, "R10 take", {31'd0, req_take}, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_status == v.st, "R1 status", {28'd0, bus_status}, {28'd0, v.st});
        chk(bus_addr == v.addr, "R10 addr", {12'd0, bus_addr}, {12'd0, v.addr});
        chk(bus_rd_n == !st_is_read(v.st), "R10 rd_n", {31'd0, bus_rd_n}, {31'd0, !st_is_read(v.st)});
        chk(bus_wr_n == st_is_read(v.st), "R10 wr_n", {31'd0, bus_wr_n}, {31'd0, st_is_read(v.st)});
        if (!st_is_read(v.st))
            chk(bus_wdata == v.wdata, "R10 wdata", {16'd0, bus_wdata}, {16'd0, v.wdata});
        chk(bus_lock_n == v.lock_n, "R6 lock", {31'd0, bus_lock_n}, {31'd0, v.lock_n});
        for (int i = 0; i < int'(v.waits); i++) begin
            bus_ready_n = 1'b1;
            @(negedge clk);
            chk(bus_status == v.st && !rsp_done, "R2 stretch", {28'd0, bus_status}, {28'd0, v.st});
            chk(bus_lock_n == v.lock_n, "R6 lock held", {31'd0, bus_lock_n}, {31'd0, v.lock_n});
        end
        bus_ready_n = 1'b0; bus_rdata = v.rdata;
        @(negedge clk);
        bus_ready_n = 1'b1;
        chk(rsp_done == 1'b1, "R9 done", {31'd0, rsp_done}, 1);
        if (st_is_read(v.st))
            chk(rsp_rdata == v.rdata, "R9 rdata", {16'd0, rsp_rdata}, {16'd0, v.rdata});
        chk(bus_status == 4'hF, "R8 idle", {28'd0, bus_status}, 32'hF);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R9 single", {31'd0, rsp_done}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        // reset state, R7
        repeat (3) @(negedge clk);
        chk(bus_status == 4'b1101, "R7 reset status", {28'd0, bus_status}, 32'hD);
        chk(!rsp_done && !hold_ack && bus_lock_n, "R7 reset outs", {29'd0, rsp_done, hold_ack, bus_lock_n}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_status == 4'b1101, "R7 boot status", {28'd0, bus_status}, 32'hD);
        chk(bus_addr == 20'hFFFF0, "R7 boot addr", {12'd0, bus_addr}, 32'hFFFF0);
        chk(bus_rd_n == 1'b0, "R7 boot rd", {31'd0, bus_rd_n}, 0);
        bus_ready_n = 1'b0; bus_rdata = 16'hEA00;
        @(negedge clk);
        bus_ready_n = 1'b1;
        chk(rsp_done && rsp_rdata == 16'hEA00, "R7 boot done", {16'd0, rsp_rdata}, 32'hEA00);

        // vector table
        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R5: short pulse ignored
        @(negedge clk);
        hold_req = 1'b1;
        repeat (2) @(negedge clk);
        hold_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!hold_ack && bus_status == 4'hF, "R5 short pulse", {31'd0, hold_ack}, 0);
        end

        // R5 / R4: qualified hold from idle, request stalled then resumed
        hold_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!hold_ack, "R5 not yet", {31'd0, hold_ack}, 0);
        end
        @(negedge clk);
        chk(hold_ack == 1'b1, "R5 ack", {31'd0, hold_ack}, 1);
        req_valid = 1'b1; req_kind = 3'd4; req_addr = 20'h0BEEF; req_lock = 1'b1;
        #1;
        chk(!req_take && bus_status == 4'hF && bus_lock_n && bus_rd_n && bus_wr_n,
            "R4 hold outs", {27'd0, req_take, bus_status}, 32'hF);
        repeat (3) @(negedge clk);
        chk(hold_ack && !req_take, "R4 stall", {30'd0, hold_ack, req_take}, 2);
        hold_req = 1'b0;
        @(negedge clk);
        chk(!hold_ack && req_take, "R4 release", {30'd0, hold_ack, req_take}, 1);
        @(negedge clk);
        req_valid = 1'b0; req_lock = 1'b0;
        chk(bus_status == 4'b1001 && bus_addr == 20'h0BEEF, "R4 resumed",
            {28'd0, bus_status}, 32'h9);
        chk(bus_lock_n == 1'b0, "R6 locked read", {31'd0, bus_lock_n}, 0);
        bus_ready_n = 1'b0; bus_rdata = 16'h7777;
        @(negedge clk);
        bus_ready_n = 1'b1;
        chk(rsp_done && rsp_rdata == 16'h7777, "R9 resumed done", {16'd0, rsp_rdata}, 32'h7777);

        // R3: hold qualifies during a stretched cycle
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd4; req_addr = 20'h00444; hold_req = 1'b1;
        bus_ready_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_status == 4'b1001 && !hold_ack, "R3 cycle start", {27'd0, hold_ack, bus_status}, 32'h9);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bus_status == 4'b1001 && !hold_ack, "R3 not cut", {27'd0, hold_ack, bus_status}, 32'h9);
        end
        bus_ready_n = 1'b0; bus_rdata = 16'h0444;
        @(negedge clk);
        bus_ready_n = 1'b1;
        chk(rsp_done && !hold_ack, "R3 done before ack", {30'd0, rsp_done, hold_ack}, 2);
        @(negedge clk);
        chk(hold_ack == 1'b1, "R3 ack after", {31'd0, hold_ack}, 1);
        hold_req = 1'b0;
        @(negedge clk);
        chk(!hold_ack && bus_status == 4'hF, "R4 exit", {27'd0, hold_ack, bus_status}, 32'hF);

        // R8: halt
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd3;
        #1;
        chk(!req_take, "R8 halt not taken", {31'd0, req_take}, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bus_status == 4'b1000, "R8 halt status", {28'd0, bus_status}, 32'h8);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(bus_status == 4'hF, "R8 halt withdrawn", {28'd0, bus_status}, 32'hF);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule